// File: doc/BRIEF.md
# Fail-Safe System Clock Monitor and Switchover

This block supervises the clock that currently drives the system and, when that clock stops, moves the system onto an always-running internal reference. A slow sample clock is made by dividing the reference by 64. Every falling edge of the watched clock (primary or secondary, whichever is selected) marks a monitor latch. Each rising sample edge clears the latch. A falling sample edge that finds the latch still clear declares a failure. The block then sets a sticky fail flag, enters the fail-safe state and steers the glitch-free clock mux onto the internal reference.

Software leaves fail-safe in one of two ways. It can write the clock-control field, which selects a new source. It can raise a sleep request, which stops the system clock. Monitoring carries on afterwards, so a later loss of the secondary clock is caught the same way.

After reset, a crystal primary runs the system from the reference until 1024 primary cycles have been counted. An external-clock or RC primary is used at once.

The fail flag is carried into the system-clock domain through two flops. It then forms the interrupt request, gated by an interrupt enable.

Top module: `clk_failsafe`

## Requirements
- R1: While reset is held, `fs_active`, `osf_flag` and `irq` are 0. With `pri_is_xtal`=0, `sys_clk` follows `pri_clk` within a few primary cycles of reset release.
- R2: With `pri_is_xtal`=1, `sys_clk` follows `ref_clk` after reset until 1024 falling edges of `pri_clk` have been counted. It then follows `pri_clk`. `fs_active` stays 0 during this start-up.
- R3: With `mon_en`=1, if the selected primary or secondary clock stops, `fs_active` and `osf_flag` rise within 2*64+8 `ref_clk` cycles. `sys_clk` then follows `ref_clk`.
- R4: A selected clock that keeps running (at least two falling edges per half sample period) never triggers a failure.
- R5: With `mon_en`=0, no failure is declared even if the selected clock stops. `fs_active` and `osf_flag` stay 0.
- R6: `irq` equals `osf_flag` taken through two `sys_clk` flops and ANDed with `fail_ie`. It is therefore 0 whenever `fail_ie`=0.
- R7: `osf_flag` stays set until an `osf_clr` pulse clears it. Clearing the flag does not end fail-safe.
- R8: A `ctl_wr` pulse ends fail-safe and selects the source coded in `clk_sel`: 00 primary, 01 secondary, 10 internal reference, 11 no clock.
- R9: A `sleep_req` pulse ends fail-safe and stops `sys_clk`. No source is selected.
- R10: After fail-safe has ended, monitoring continues. If the secondary clock is then selected and stops, fail-safe is entered again and `sys_clk` follows `ref_clk`.
- R11: Outside reset, `sys_clk` never shows a high or low phase shorter than half a `ref_clk` period. No more than one source is enabled in the mux at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running internal reference; also the fail-safe clock |
| pri_clk | input | 1 | Primary oscillator clock |
| sec_clk | input | 1 | Secondary oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Monitoring enable configuration bit |
| pri_is_xtal | input | 1 | Primary is a crystal needing a start-up count |
| clk_sel | input | 2 | Source code applied by a control write |
| ctl_wr | input | 1 | One-cycle clock-control write strobe (ref domain) |
| sleep_req | input | 1 | One-cycle sleep request (ref domain) |
| fail_ie | input | 1 | Fail interrupt enable |
| osf_clr | input | 1 | One-cycle clear of the fail flag (ref domain) |
| sys_clk | output | 1 | Selected system clock |
| osf_flag | output | 1 | Sticky oscillator-fail flag |
| irq | output | 1 | Fail interrupt request |
| fs_active | output | 1 | Fail-safe state is active |

## Verification
Loss of the primary clock is tried at sixteen stop instants spread across one whole sample period. The measured detection latency shows that the latch test catches the loss in every phase of the sample clock, and alternating `fail_ie` separates the flag from the gated interrupt. The watched clock is also kept running for thousands of cycles, stopped with monitoring disabled, and stopped again after exit to the secondary source. These runs tell genuine detection apart from false alarms, from a dead enable and from monitoring that quits after exit. Edge counts of `sys_clk` over a fixed window identify the active source, and so distinguish primary, secondary, reference, no-clock and the crystal start-up hold before and after its 1024th edge.

// File: rtl/cfs_pkg.sv
`timescale 1ns/1ps
package cfs_pkg;
  // Source encoding shared by the clock-select field and the mux.
  typedef enum logic [1:0] {
    SRC_PRI  = 2'b00,
    SRC_SEC  = 2'b01,
    SRC_INT  = 2'b10,
    SRC_NONE = 2'b11
  } src_e;

  // Mux lane order: bit 0 primary, bit 1 secondary, bit 2 internal reference.
  localparam int NUM_LANES = 3;

  function automatic logic [NUM_LANES-1:0] src_onehot(src_e s);
    case (s)
      SRC_PRI: return 3'b001;
      SRC_SEC: return 3'b010;
      SRC_INT: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  // Position of the falling sample edge inside one divider period.
  function automatic int unsigned fall_point(int unsigned div_log2);
    return (1 << div_log2) / 2;
  endfunction

  // Worst-case reference cycles from clock loss to the fail-safe state.
  function automatic int unsigned fail_bound(int unsigned div_log2, int unsigned sync_slack);
    return 2 * (1 << div_log2) + sync_slack;
  endfunction
endpackage

// File: rtl/cfs_sample_div.sv
`timescale 1ns/1ps
module cfs_sample_div #(
  parameter int DIV_LOG2 = 6
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic smp_rise,
  output logic smp_fall
);
  localparam int unsigned HALF = cfs_pkg::fall_point(DIV_LOG2);

  logic [DIV_LOG2-1:0] phase_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + 1'b1;
  end

  assign smp_rise = (phase_q == '0);
  assign smp_fall = (phase_q == DIV_LOG2'(HALF));
endmodule

// File: rtl/cfs_edge_seen.sv
`timescale 1ns/1ps
module cfs_edge_seen (
  input  logic mon_clk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic seen
);
  // Toggle on every falling edge of the watched clock, then carry it over.
  logic tog_q;
  logic [2:0] sync_q;

  always_ff @(negedge mon_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tog_q};
  end

  assign seen = sync_q[2] ^ sync_q[1];
endmodule

// File: rtl/cfs_ctrl.sv
`timescale 1ns/1ps
module cfs_ctrl #(
  parameter int OST_CYCLES = 1024
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic             pri_is_xtal,
  input  logic [1:0]       clk_sel,
  input  logic             ctl_wr,
  input  logic             sleep_req,
  input  logic             osf_clr,
  input  logic             seen_pri,
  input  logic             seen_sec,
  input  logic             smp_rise,
  input  logic             smp_fall,
  output cfs_pkg::src_e    src,
  output logic             fs_active,
  output logic             osf
);
  import cfs_pkg::*;
  localparam int OST_W = $clog2(OST_CYCLES + 1);

  logic             booting;
  logic             ost_busy;
  logic [OST_W-1:0] ost_cnt;
  logic             cm;

  // Named internal events for the assertions.
  logic ost_done;
  logic arm;
  logic seen_mon;
  logic mon_active;
  logic fail_evt;

  assign ost_done   = ost_busy && seen_pri && (ost_cnt == OST_W'(OST_CYCLES - 1));
  assign arm        = booting || sleep_req || ctl_wr || ost_done;
  assign seen_mon   = (src == SRC_SEC) ? seen_sec : seen_pri;
  assign mon_active = mon_en && !booting && !ost_busy && (src == SRC_PRI || src == SRC_SEC);
  assign fail_evt   = mon_active && smp_fall && !cm && !arm;

  // Monitor latch: marked by watched-clock edges, cleared by the sample rise,
  // re-armed whenever the watched source changes.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)        cm <= 1'b1;
    else if (arm)      cm <= 1'b1;
    else if (smp_rise) cm <= 1'b0;
    else if (seen_mon) cm <= 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      booting   <= 1'b1;
      src       <= SRC_INT;
      fs_active <= 1'b0;
      ost_busy  <= 1'b0;
      ost_cnt   <= '0;
    end else begin
      booting <= 1'b0;
      if (booting) begin
        if (pri_is_xtal) begin
          ost_busy <= 1'b1;
          ost_cnt  <= '0;
        end else begin
          src <= SRC_PRI;
        end
      end else if (sleep_req) begin
        src       <= SRC_NONE;
        fs_active <= 1'b0;
        ost_busy  <= 1'b0;
      end else if (ctl_wr) begin
        src       <= src_e'(clk_sel);
        fs_active <= 1'b0;
        ost_busy  <= 1'b0;
      end else if (ost_busy) begin
        if (ost_done) begin
          ost_busy <= 1'b0;
          src      <= SRC_PRI;
        end else if (seen_pri) begin
          ost_cnt <= ost_cnt + 1'b1;
        end
      end else if (fail_evt) begin
        src       <= SRC_INT;
        fs_active <= 1'b1;
      end
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)        osf <= 1'b0;
    else if (fail_evt) osf <= 1'b1;
    else if (osf_clr)  osf <= 1'b0;
  end

  AST_FAIL_TO_INT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_evt |=> (src == SRC_INT) && fs_active && osf); // R3
  AST_FLAG_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (osf && !osf_clr) |=> osf); // R7
  AST_QUIET_WHEN_OFF: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !mon_en |=> !$rose(fs_active)); // R5
  AST_OST_ON_INT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ost_busy |-> (src == SRC_INT) && !fs_active); // R2
  AST_SLEEP_EXIT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (sleep_req && !booting) |=> (src == SRC_NONE) && !fs_active); // R9
  AST_WRITE_EXIT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ctl_wr && !sleep_req && !booting) |=> !fs_active && (src == $past(clk_sel))); // R8
endmodule

// File: rtl/cfs_clk_mux.sv
`timescale 1ns/1ps
module cfs_clk_mux #(
  parameter int N = 3
) (
  input  logic [N-1:0] clks,
  input  logic [N-1:0] sel_oh,
  input  logic [N-1:0] kill,
  input  logic         rst_n,
  output logic [N-1:0] en,
  output logic         clk_out
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    localparam logic [N-1:0] MY_BIT = N'(1) << g;
    logic others_on;
    logic lane_rst_n;
    logic arm_q;
    logic en_q;

    assign others_on  = |(en & ~MY_BIT);
    // A lane whose clock has died cannot retire itself; kill clears it while low.
    assign lane_rst_n = rst_n & ~kill[g];

    always_ff @(posedge clks[g] or negedge lane_rst_n) begin
      if (!lane_rst_n) arm_q <= 1'b0;
      else             arm_q <= sel_oh[g] & ~others_on;
    end

    // Enable changes only while this lane's clock is low.
    always_ff @(negedge clks[g] or negedge lane_rst_n) begin
      if (!lane_rst_n) en_q <= 1'b0;
      else             en_q <= arm_q;
    end

    assign en[g] = en_q;
  end

  assign clk_out = |(clks & en);

  AST_ONE_LANE_ON: assert property (@(posedge clks[N-1]) disable iff (!rst_n)
    $onehot0(en)); // R11
endmodule

// File: rtl/clk_failsafe.sv
`timescale 1ns/1ps
module clk_failsafe #(
  parameter int DIV_LOG2   = 6,
  parameter int OST_CYCLES = 1024
) (
  input  logic       ref_clk,
  input  logic       pri_clk,
  input  logic       sec_clk,
  input  logic       rst_n,
  input  logic       mon_en,
  input  logic       pri_is_xtal,
  input  logic [1:0] clk_sel,
  input  logic       ctl_wr,
  input  logic       sleep_req,
  input  logic       fail_ie,
  input  logic       osf_clr,
  output logic       sys_clk,
  output logic       osf_flag,
  output logic       irq,
  output logic       fs_active
);
  import cfs_pkg::*;

  logic       smp_rise, smp_fall;
  logic [1:0] watched_clks;
  logic [1:0] seen;
  src_e       src;
  logic [NUM_LANES-1:0] lane_en;
  logic [NUM_LANES-1:0] lane_kill;
  logic [1:0] irq_sync_q;

  cfs_sample_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .smp_rise(smp_rise),
    .smp_fall(smp_fall)
  );

  assign watched_clks = {sec_clk, pri_clk};
  for (genvar w = 0; w < 2; w++) begin : g_watch
    cfs_edge_seen u_seen (
      .mon_clk(watched_clks[w]),
      .ref_clk(ref_clk),
      .rst_n  (rst_n),
      .seen   (seen[w])
    );
  end

  cfs_ctrl #(.OST_CYCLES(OST_CYCLES)) u_ctrl (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .mon_en     (mon_en),
    .pri_is_xtal(pri_is_xtal),
    .clk_sel    (clk_sel),
    .ctl_wr     (ctl_wr),
    .sleep_req  (sleep_req),
    .osf_clr    (osf_clr),
    .seen_pri   (seen[0]),
    .seen_sec   (seen[1]),
    .smp_rise   (smp_rise),
    .smp_fall   (smp_fall),
    .src        (src),
    .fs_active  (fs_active),
    .osf        (osf_flag)
  );

  // In fail-safe the oscillator lanes are forced off; a dead clock rests low.
  assign lane_kill = {1'b0, fs_active, fs_active};

  cfs_clk_mux #(.N(NUM_LANES)) u_mux (
    .clks   ({ref_clk, sec_clk, pri_clk}),
    .sel_oh (src_onehot(src)),
    .kill   (lane_kill),
    .rst_n  (rst_n),
    .en     (lane_en),
    .clk_out(sys_clk)
  );

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) irq_sync_q <= '0;
    else        irq_sync_q <= {irq_sync_q[0], osf_flag};
  end

  assign irq = irq_sync_q[1] & fail_ie;

  AST_FS_ON_REF: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fs_active && $past(fs_active)) |-> (lane_en[1:0] == 2'b00)); // R3
endmodule

// File: tb/clk_failsafe_tb_top.sv
`timescale 1ns/1ps
module clk_failsafe_tb_top;
  localparam int    DIV_LOG2 = 6;
  localparam int    OST      = 1024;
  localparam int    BOUND    = 2 * (1 << DIV_LOG2) + 8;
  localparam real   REF_P    = 4.0;
  localparam real   PRI_P    = 20.0;
  localparam real   SEC_P    = 52.0;
  localparam int    WIN      = 1040;
  localparam int    EXP_PRI  = WIN / 20;
  localparam int    EXP_SEC  = WIN / 52;
  localparam int    EXP_INT  = WIN / 4;

  logic ref_clk = 1'b0, pri_clk = 1'b0, sec_clk = 1'b0;
  logic pri_run = 1'b1, sec_run = 1'b1;
  logic rst_n = 1'b0, mon_en = 1'b1, pri_is_xtal = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic ctl_wr = 1'b0, sleep_req = 1'b0, fail_ie = 1'b0, osf_clr = 1'b0;
  logic sys_clk, osf_flag, irq, fs_active;

  int checks = 0, errors = 0, edges = 0, glitches = 0;
  realtime last_t = 0.0;
  bit prev_ok = 1'b0;

  clk_failsafe #(.DIV_LOG2(DIV_LOG2), .OST_CYCLES(OST)) dut_i (
    .ref_clk(ref_clk), .pri_clk(pri_clk), .sec_clk(sec_clk), .rst_n(rst_n),
    .mon_en(mon_en), .pri_is_xtal(pri_is_xtal), .clk_sel(clk_sel), .ctl_wr(ctl_wr),
    .sleep_req(sleep_req), .fail_ie(fail_ie), .osf_clr(osf_clr),
    .sys_clk(sys_clk), .osf_flag(osf_flag), .irq(irq), .fs_active(fs_active)
  );

  initial forever #(REF_P / 2) ref_clk = ~ref_clk;
  initial forever begin #(PRI_P / 2); pri_clk = pri_run ? ~pri_clk : 1'b0; end
  initial forever begin #(SEC_P / 2); sec_clk = sec_run ? ~sec_clk : 1'b0; end

  always @(posedge sys_clk) edges++;

  // R11: phase widths of the output clock, outside reset.
  always @(sys_clk) begin
    if (rst_n && prev_ok && ($realtime - last_t) < (REF_P / 2 - 0.5)) glitches++;
    last_t  = $realtime;
    prev_ok = rst_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic measure(output int n);
    int c0;
    c0 = edges;
    #(WIN);
    n = edges - c0;
    @(negedge ref_clk);
  endtask

  task automatic chk_src(input string tag, input int exp);
    int n;
    measure(n);
    chk((n >= exp - 2) && (n <= exp + 2), tag, n, exp);
  endtask

  task automatic do_reset(input logic xtal, input bit check_idle);
    @(negedge ref_clk);
    rst_n = 1'b0;
    pri_is_xtal = xtal;
    ctl_wr = 0; sleep_req = 0; osf_clr = 0;
    cyc(4);
    if (check_idle) begin
      chk(fs_active == 1'b0, "R1 reset fs_active", fs_active, 0);
      chk(osf_flag == 1'b0, "R1 reset osf_flag", osf_flag, 0);
      chk(irq == 1'b0, "R1 reset irq", irq, 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic wr_sel(input logic [1:0] sel);
    clk_sel = sel;
    ctl_wr = 1'b1;
    cyc(1);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_fail(output int lat);
    lat = 0;
    while (!fs_active && lat < 400) begin
      cyc(1);
      lat++;
    end
  endtask

  initial begin
    int lat;
    // Watchdog
    #(400000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    // R1: reset state and immediate primary
    do_reset(1'b0, 1'b1);
    cyc(150);
    chk_src("R1 sys_clk on primary", EXP_PRI);
    // R4: running clock, long run
    cyc(2000);
    chk(fs_active == 1'b0, "R4 no false fail-safe", fs_active, 0);
    chk(osf_flag == 1'b0, "R4 no false flag", osf_flag, 0);

    // R3/R6: stop the primary at sixteen phases of the sample period
    for (int k = 0; k < 16; k++) begin
      pri_run = 1'b1;
      fail_ie = k[0];
      do_reset(1'b0, 1'b0);
      cyc(100 + 4 * k);
      pri_run = 1'b0;
      wait_fail(lat);
      chk(fs_active && lat <= BOUND, "R3 detection latency", lat, BOUND);
      chk(osf_flag == 1'b1, "R3 flag set", osf_flag, 1);
      cyc(20);
      chk(irq == fail_ie, "R6 irq gated by enable", irq, fail_ie);
    end
    chk_src("R3 sys_clk on reference", EXP_INT);

    // R7: flag sticky, clear leaves fail-safe
    cyc(500);
    chk(osf_flag == 1'b1, "R7 flag held", osf_flag, 1);
    osf_clr = 1'b1; cyc(1); osf_clr = 1'b0;
    cyc(10);
    chk(osf_flag == 1'b0, "R7 flag cleared", osf_flag, 0);
    chk(fs_active == 1'b1, "R7 fail-safe kept", fs_active, 1);
    chk(irq == 1'b0, "R6 irq drops with flag", irq, 0);

    // R8: write selects secondary (01)
    wr_sel(2'b01);
    chk(fs_active == 1'b0, "R8 write ends fail-safe", fs_active, 0);
    cyc(100);
    chk_src("R8 sys_clk on secondary", EXP_SEC);
    // R10: secondary loss after exit
    sec_run = 1'b0;
    wait_fail(lat);
    chk(fs_active && lat <= BOUND, "R10 secondary loss caught", lat, BOUND);
    cyc(50);
    chk_src("R10 sys_clk back on reference", EXP_INT);
    sec_run = 1'b1;
    // R8: internal (10), primary (00), none (11)
    wr_sel(2'b10);
    chk(fs_active == 1'b0, "R8 write internal ends fail-safe", fs_active, 0);
    cyc(50);
    chk_src("R8 sys_clk on internal", EXP_INT);
    pri_run = 1'b1;
    wr_sel(2'b00);
    cyc(100);
    chk_src("R8 sys_clk on primary", EXP_PRI);
    wr_sel(2'b11);
    cyc(100);
    chk_src("R8 sys_clk stopped", 0);

    // R9: sleep request ends fail-safe
    wr_sel(2'b00);
    cyc(100);
    pri_run = 1'b0;
    wait_fail(lat);
    chk(fs_active == 1'b1, "R9 fail-safe entered", fs_active, 1);
    sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
    chk(fs_active == 1'b0, "R9 sleep ends fail-safe", fs_active, 0);
    cyc(50);
    chk_src("R9 sys_clk stopped", 0);

    // R5: monitoring disabled
    pri_run = 1'b1;
    mon_en = 1'b0;
    do_reset(1'b0, 1'b0);
    cyc(200);
    pri_run = 1'b0;
    cyc(1000);
    chk(fs_active == 1'b0, "R5 no fail-safe when disabled", fs_active, 0);
    chk(osf_flag == 1'b0, "R5 no flag when disabled", osf_flag, 0);
    chk_src("R5 sys_clk stays on dead primary", 0);

    // R2: crystal start-up count
    mon_en = 1'b1;
    pri_run = 1'b1;
    do_reset(1'b1, 1'b0);
    cyc(100);
    chk_src("R2 start-up on reference", EXP_INT);
    chk(fs_active == 1'b0, "R2 no fail-safe in start-up", fs_active, 0);
    #(int'(OST * PRI_P) - 3800);
    @(negedge ref_clk);
    chk_src("R2 still on reference before count ends", EXP_INT);
    #(3000);
    @(negedge ref_clk);
    chk_src("R2 primary after count", EXP_PRI);
    chk(fs_active == 1'b0, "R2 no fail-safe after start-up", fs_active, 0);

    chk(glitches == 0, "R11 no runt phases on sys_clk", glitches, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule